// File: doc/BRIEF.md
# MII Receive Frame Assembler

This block sits on the receive side of a 4-bit media-independent port, running on the receive clock. It watches the nibble stream, a data-valid line and an error line. It throws away the preamble, finds the start-of-frame delimiter and pairs the nibbles that follow into bytes. The bytes go out as a stream of valid beats. The first byte carries a start flag and the last byte carries an end flag together with a per-frame error flag. The assembler does not need to see the whole preamble: data-valid may rise part-way through it, and byte alignment is taken from the delimiter alone.

Between frames the error line and the data lines together carry side information, and the block decodes two codes from them. One code says the link partner is in low-power idle. It is reported as a level that stays high while the code is present. The other code reports a false carrier and is reported as a one-cycle pulse for each occurrence. CRC checking, address filtering and clock recovery belong to other blocks.

Top module: `mii_rx_assembler`

## Requirements
- R1: While reset is asserted and on the first clock after it is released, `beat_valid`, `beat_first`, `beat_last`, `beat_bad`, `lpi_seen` and `false_carrier` are all low.
- R2: When `rx_valid` is high, the block hunts for the delimiter. The delimiter is nibble 0x5 followed directly by nibble 0xD, and any number of 0x5 nibbles (one or more) may come before the 0xD. No nibble up to and including the 0xD is ever output.
- R3: After the delimiter, nibbles are paired into bytes. The first nibble of each pair becomes bits 3:0 of `beat_data` and the second nibble becomes bits 7:4. Bytes are output in the order they were received.
- R4: `beat_first` is high on the first byte of a frame and low on every other byte.
- R5: One byte is always held back inside the block. It is released either when the next byte completes or when `rx_valid` falls. `beat_last` is high only on the byte released by the fall of `rx_valid`, and that beat appears in the same cycle in which `rx_valid` is sampled low.
- R6: If `rx_err` is sampled high while `rx_valid` is high, anywhere from the rise of `rx_valid` to its fall, `beat_bad` is high on that frame's last beat. `beat_bad` is never high on a beat that is not the last.
- R7: If `rx_valid` falls after an odd number of nibbles following the delimiter, `beat_bad` is high on the last beat. The unpaired nibble is dropped.
- R8: If `rx_valid` falls before the delimiter, or before the first byte is complete, the frame produces no beats.
- R9: `lpi_seen` goes high one cycle after the inputs are sampled with `rx_valid` low, `rx_err` high and `rx_data` equal to 0x1. It stays high for as long as that code continues.
- R10: `false_carrier` is high for exactly one cycle after the first cycle in which `rx_valid` is low, `rx_err` is high and `rx_data` is 0xE. It stays low while the code continues.
- R11: When `rx_err` is high with any other data value while `rx_valid` is low, or when `rx_err` is high with any value while `rx_valid` is high, neither `lpi_seen` nor `false_carrier` is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_data | input | 4 | Receive nibble |
| rx_valid | input | 1 | Receive data valid |
| rx_err | input | 1 | Receive error / sideband qualifier |
| beat_valid | output | 1 | Output byte valid |
| beat_data | output | 8 | Output byte |
| beat_first | output | 1 | First byte of frame |
| beat_last | output | 1 | Last byte of frame |
| beat_bad | output | 1 | Frame error, meaningful with `beat_last` |
| lpi_seen | output | 1 | Link partner low-power idle (level) |
| false_carrier | output | 1 | False carrier detected (pulse) |

## Verification
Three edge cases are hard to reach from the ports. In the first, the delimiter comes right after a single preamble nibble, as if data-valid rose late. In the second, an error is raised on the very nibble that completes the delimiter or on the last data nibble. In the third, the frame ends while only one byte is held back. The stimulus mixes these on purpose with random preamble lengths from one to seven nibbles, random byte counts including zero and one, optional trailing odd nibbles, and error pulses at random nibble positions. Directed sequences also drop data-valid inside the preamble and hold the sideband codes across several cycles.

// File: rtl/mii_rx_pkg.sv
package mii_rx_pkg;
   typedef enum logic {
      ST_HUNT = 1'b0,
      ST_DATA = 1'b1
   } rx_state_e;

   function automatic logic nib_match(input logic [7:0] a, input logic [7:0] b);
      return a == b;
   endfunction
endpackage

// File: rtl/mii_rx_align.sv
module mii_rx_align
   import mii_rx_pkg::*;
#(
   parameter int          NIB_W   = 4,
   parameter logic [7:0]  PRE_NIB = 8'h05,
   parameter logic [7:0]  SFD_NIB = 8'h0D
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             dv_i,
   input  logic [NIB_W-1:0] nib_i,
   output logic             in_data_o,
   output logic             sfd_hit_o,
   output logic             take_o,
   output logic             end_o
);
   rx_state_e st_q;
   logic      prev_pre_q;
   logic      is_pre, is_sfd;

   assign is_pre    = nib_match(8'(nib_i), PRE_NIB);
   assign is_sfd    = nib_match(8'(nib_i), SFD_NIB);
   assign in_data_o = (st_q == ST_DATA);
   assign sfd_hit_o = dv_i && (st_q == ST_HUNT) && prev_pre_q && is_sfd;
   assign take_o    = dv_i && (st_q == ST_DATA);
   assign end_o     = !dv_i && (st_q == ST_DATA);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q       <= ST_HUNT;
         prev_pre_q <= 1'b0;
      end else if (!dv_i) begin
         st_q       <= ST_HUNT;
         prev_pre_q <= 1'b0;
      end else if (st_q == ST_HUNT) begin
         prev_pre_q <= is_pre;
         if (sfd_hit_o) st_q <= ST_DATA;
      end
   end

   // R2: data phase is only entered from a valid delimiter nibble
   p_entry_on_sfd_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(st_q == ST_DATA) |-> ($past(dv_i) && $past(is_sfd)));
endmodule

// File: rtl/mii_rx_pack.sv
module mii_rx_pack #(
   parameter int NIB_W    = 4,
   parameter bit LO_FIRST = 1'b1,
   localparam int BYTE_W  = 2 * NIB_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              dv_i,
   input  logic              er_i,
   input  logic [NIB_W-1:0]  nib_i,
   input  logic              sfd_i,
   input  logic              take_i,
   input  logic              end_i,
   output logic              valid_o,
   output logic [BYTE_W-1:0] data_o,
   output logic              first_o,
   output logic              last_o,
   output logic              bad_o
);
   logic              have_half_q;
   logic [NIB_W-1:0]  half_q;
   logic              held_v_q, held_first_q, first_pend_q, err_acc_q;
   logic [BYTE_W-1:0] held_q;
   logic [BYTE_W-1:0] byte_n;

   generate
      if (LO_FIRST) begin : g_lo_first
         assign byte_n = {nib_i, half_q};
      end else begin : g_hi_first
         assign byte_n = {half_q, nib_i};
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         have_half_q  <= 1'b0;
         half_q       <= '0;
         held_v_q     <= 1'b0;
         held_first_q <= 1'b0;
         first_pend_q <= 1'b0;
         err_acc_q    <= 1'b0;
         held_q       <= '0;
         valid_o      <= 1'b0;
         data_o       <= '0;
         first_o      <= 1'b0;
         last_o       <= 1'b0;
         bad_o        <= 1'b0;
      end else begin
         valid_o <= 1'b0;
         first_o <= 1'b0;
         last_o  <= 1'b0;
         bad_o   <= 1'b0;
         if (!dv_i)     err_acc_q <= 1'b0;
         else if (er_i) err_acc_q <= 1'b1;
         if (sfd_i) begin
            have_half_q  <= 1'b0;
            held_v_q     <= 1'b0;
            first_pend_q <= 1'b1;
         end else if (take_i) begin
            if (!have_half_q) begin
               half_q      <= nib_i;
               have_half_q <= 1'b1;
            end else begin
               have_half_q  <= 1'b0;
               held_q       <= byte_n;
               held_first_q <= first_pend_q;
               first_pend_q <= 1'b0;
               held_v_q     <= 1'b1;
               if (held_v_q) begin
                  valid_o <= 1'b1;
                  data_o  <= held_q;
                  first_o <= held_first_q;
               end
            end
         end else if (end_i) begin
            have_half_q  <= 1'b0;
            held_v_q     <= 1'b0;
            first_pend_q <= 1'b0;
            if (held_v_q) begin
               valid_o <= 1'b1;
               data_o  <= held_q;
               first_o <= held_first_q;
               last_o  <= 1'b1;
               bad_o   <= err_acc_q | have_half_q;
            end
         end
      end
   end

   // R6: error flag only rides on the closing beat
   p_bad_on_last_r6: assert property (@(posedge clk) disable iff (!rst_n)
      bad_o |-> last_o);
   // R5: closing beat is a real beat and follows the fall of data-valid
   p_last_after_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
      last_o |-> (valid_o && !$past(dv_i)));
   // R4: start flag only on a valid beat
   p_first_valid_r4: assert property (@(posedge clk) disable iff (!rst_n)
      first_o |-> valid_o);
endmodule

// File: rtl/mii_rx_sideband.sv
module mii_rx_sideband #(
   parameter int         NIB_W    = 4,
   parameter logic [7:0] LPI_CODE = 8'h01,
   parameter logic [7:0] FC_CODE  = 8'h0E,
   parameter bit         FC_PULSE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             dv_i,
   input  logic             er_i,
   input  logic [NIB_W-1:0] nib_i,
   output logic             lpi_o,
   output logic             fc_o
);
   logic side, lpi_cond, fc_cond;

   assign side     = !dv_i && er_i;
   assign lpi_cond = side && (8'(nib_i) == LPI_CODE);
   assign fc_cond  = side && (8'(nib_i) == FC_CODE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lpi_o <= 1'b0;
      else        lpi_o <= lpi_cond;
   end

   generate
      if (FC_PULSE) begin : g_fc_pulse
         logic fc_seen_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               fc_seen_q <= 1'b0;
               fc_o      <= 1'b0;
            end else begin
               fc_seen_q <= fc_cond;
               fc_o      <= fc_cond && !fc_seen_q;
            end
         end
         // R10: one pulse per occurrence
         p_fc_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
            fc_o |=> !fc_o);
      end else begin : g_fc_level
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) fc_o <= 1'b0;
            else        fc_o <= fc_cond;
         end
      end
   endgenerate

   // R9 / R11: sideband indications need data-valid low in the prior cycle
   p_side_out_of_frame_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (lpi_o || fc_o) |-> (!$past(dv_i) && $past(er_i)));
   p_lpi_fc_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !(lpi_o && fc_o));
endmodule

// File: rtl/mii_rx_assembler.sv
module mii_rx_assembler #(
   parameter int          NIB_W    = 4,
   parameter logic [7:0]  PRE_NIB  = 8'h05,
   parameter logic [7:0]  SFD_NIB  = 8'h0D,
   parameter logic [7:0]  LPI_CODE = 8'h01,
   parameter logic [7:0]  FC_CODE  = 8'h0E,
   parameter bit          LO_FIRST = 1'b1,
   parameter bit          FC_PULSE = 1'b1,
   localparam int         BYTE_W   = 2 * NIB_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NIB_W-1:0]  rx_data,
   input  logic              rx_valid,
   input  logic              rx_err,
   output logic              beat_valid,
   output logic [BYTE_W-1:0] beat_data,
   output logic              beat_first,
   output logic              beat_last,
   output logic              beat_bad,
   output logic              lpi_seen,
   output logic              false_carrier
);
   generate
      if (NIB_W < 2 || NIB_W > 8) begin : g_bad_width
         $error("mii_rx_assembler: NIB_W out of range");
      end
      if (PRE_NIB == SFD_NIB) begin : g_bad_sfd
         $error("mii_rx_assembler: preamble and delimiter nibbles must differ");
      end
      if (LPI_CODE == FC_CODE) begin : g_bad_codes
         $error("mii_rx_assembler: sideband codes must differ");
      end
   endgenerate

   logic in_data, sfd_hit, take, frame_end;

   mii_rx_align #(.NIB_W(NIB_W), .PRE_NIB(PRE_NIB), .SFD_NIB(SFD_NIB)) u_align (
      .clk(clk), .rst_n(rst_n), .dv_i(rx_valid), .nib_i(rx_data),
      .in_data_o(in_data), .sfd_hit_o(sfd_hit), .take_o(take), .end_o(frame_end)
   );

   mii_rx_pack #(.NIB_W(NIB_W), .LO_FIRST(LO_FIRST)) u_pack (
      .clk(clk), .rst_n(rst_n), .dv_i(rx_valid), .er_i(rx_err), .nib_i(rx_data),
      .sfd_i(sfd_hit), .take_i(take), .end_i(frame_end),
      .valid_o(beat_valid), .data_o(beat_data), .first_o(beat_first),
      .last_o(beat_last), .bad_o(beat_bad)
   );

   mii_rx_sideband #(.NIB_W(NIB_W), .LPI_CODE(LPI_CODE), .FC_CODE(FC_CODE),
                     .FC_PULSE(FC_PULSE)) u_side (
      .clk(clk), .rst_n(rst_n), .dv_i(rx_valid), .er_i(rx_err), .nib_i(rx_data),
      .lpi_o(lpi_seen), .fc_o(false_carrier)
   );

   // R8: every output beat comes from a frame already in its data phase
   p_beat_in_frame_r8: assert property (@(posedge clk) disable iff (!rst_n)
      beat_valid |-> $past(in_data));
endmodule

// File: tb/mii_rx_assembler_tb.sv
module mii_rx_assembler_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] rx_data = 4'h0;
   logic       rx_valid = 1'b0;
   logic       rx_err = 1'b0;
   logic       beat_valid, beat_first, beat_last, beat_bad, lpi_seen, false_carrier;
   logic [7:0] beat_data;

   always #4 clk = ~clk;

   mii_rx_assembler u_dut (
      .clk(clk), .rst_n(rst_n), .rx_data(rx_data), .rx_valid(rx_valid), .rx_err(rx_err),
      .beat_valid(beat_valid), .beat_data(beat_data), .beat_first(beat_first),
      .beat_last(beat_last), .beat_bad(beat_bad), .lpi_seen(lpi_seen),
      .false_carrier(false_carrier)
   );

   int n_chk = 0;
   int n_bad = 0;
   int cyc_cnt = 0;
   bit done = 0;

   logic [7:0] obs_d [64];
   logic       obs_f [64], obs_l [64], obs_e [64];
   int         obs_cnt = 0;
   logic [7:0] exp_b [64];
   logic [3:0] seq [160];
   bit         sb_leak;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n && beat_valid && obs_cnt < 64) begin
         obs_d[obs_cnt] = beat_data;
         obs_f[obs_cnt] = beat_first;
         obs_l[obs_cnt] = beat_last;
         obs_e[obs_cnt] = beat_bad;
         obs_cnt++;
      end
   end

   always @(posedge clk) begin
      cyc_cnt++;
      if (cyc_cnt > 150000 && !done) begin
         done = 1;
         n_bad++;
         $display("FAIL watchdog: actual %0d expected %0d", cyc_cnt, 150000);
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   task automatic cyc(input logic dv, input logic er, input logic [3:0] d);
      @(negedge clk);
      rx_valid = dv; rx_err = er; rx_data = d;
      @(posedge clk);
      #1;
      if (dv && (lpi_seen || false_carrier)) sb_leak = 1;
   endtask

   function automatic bit exp_bad(input int err_pos, input bit odd);
      return (err_pos >= 0) || odd;
   endfunction

   // p preamble 0x5 nibbles, delimiter, n bytes, optional odd nibble, error at err_pos
   task automatic run_frame(input int p, input int n, input bit odd, input int err_pos);
      int len = 0;
      obs_cnt = 0;
      sb_leak = 0;
      for (int i = 0; i < p; i++) begin seq[len] = 4'h5; len++; end
      seq[len] = 4'hD; len++;
      for (int k = 0; k < n; k++) begin
         exp_b[k] = 8'($urandom);
         seq[len] = exp_b[k][3:0]; len++;
         seq[len] = exp_b[k][7:4]; len++;
      end
      if (odd) begin seq[len] = 4'($urandom); len++; end
      for (int i = 0; i < len; i++) cyc(1'b1, (i == err_pos), seq[i]);
      for (int i = 0; i < 3; i++) cyc(1'b0, 1'b0, 4'h0);
      chk(!sb_leak, "R11 no sideband in frame", sb_leak, 0);
      if (n == 0) begin
         chk(obs_cnt == 0, "R8 runt gives no beats", obs_cnt, 0);
      end else begin
         chk(obs_cnt == n, "R2 beat count", obs_cnt, n);
         for (int k = 0; k < n && k < obs_cnt; k++) begin
            chk(obs_d[k] == exp_b[k], "R3 byte value", obs_d[k], exp_b[k]);
            chk(obs_f[k] == (k == 0), "R4 first flag", obs_f[k], (k == 0));
            chk(obs_l[k] == (k == n-1), "R5 last flag", obs_l[k], (k == n-1));
            if (k == n-1)
               chk(obs_e[k] == exp_bad(err_pos, odd), (odd ? "R7 odd nibble" : "R6 error flag"),
                   obs_e[k], exp_bad(err_pos, odd));
            else
               chk(obs_e[k] == 1'b0, "R6 no error mid frame", obs_e[k], 0);
         end
      end
   endtask

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(posedge clk);
      #1;
      chk(!beat_valid && !beat_first && !beat_last && !beat_bad && !lpi_seen && !false_carrier,
          "R1 reset outputs", {beat_valid, beat_first, beat_last, beat_bad, lpi_seen, false_carrier}, 0);
      @(negedge clk); rst_n = 1'b1;
      cyc(1'b0, 1'b0, 4'h0);
      chk(!beat_valid && !lpi_seen && !false_carrier, "R1 after reset", beat_valid, 0);

      // directed: late data-valid with one preamble nibble, single byte
      run_frame(1, 1, 1'b0, -1);
      // directed: error on the delimiter nibble
      run_frame(3, 4, 1'b0, 3);
      // directed: error on the final data nibble of a one-byte frame
      run_frame(2, 1, 1'b0, 4);
      // directed: odd trailing nibble
      run_frame(7, 5, 1'b1, -1);
      // directed: only one nibble after delimiter (R8)
      run_frame(4, 0, 1'b1, -1);
      // directed: delimiter then immediate fall (R8)
      run_frame(2, 0, 1'b0, -1);

      // directed: data-valid drops inside preamble (R8)
      obs_cnt = 0;
      for (int i = 0; i < 4; i++) cyc(1'b1, 1'b0, 4'h5);
      for (int i = 0; i < 3; i++) cyc(1'b0, 1'b0, 4'h0);
      chk(obs_cnt == 0, "R8 fall in preamble", obs_cnt, 0);

      // directed: 0xD without preceding 0x5 is not a delimiter (R2)
      obs_cnt = 0;
      cyc(1'b1, 1'b0, 4'hD); cyc(1'b1, 1'b0, 4'h3); cyc(1'b1, 1'b0, 4'h4);
      for (int i = 0; i < 3; i++) cyc(1'b0, 1'b0, 4'h0);
      chk(obs_cnt == 0, "R2 lone 0xD ignored", obs_cnt, 0);

      // directed: low-power idle level (R9)
      for (int i = 0; i < 3; i++) begin
         cyc(1'b0, 1'b1, 4'h1);
         chk(lpi_seen == 1'b1, "R9 lpi level", lpi_seen, 1);
         chk(false_carrier == 1'b0, "R9 no fc during lpi", false_carrier, 0);
      end
      cyc(1'b0, 1'b0, 4'h1);
      chk(lpi_seen == 1'b0, "R9 lpi drops", lpi_seen, 0);

      // directed: false carrier pulse (R10)
      cyc(1'b0, 1'b1, 4'hE);
      chk(false_carrier == 1'b1, "R10 fc pulse", false_carrier, 1);
      cyc(1'b0, 1'b1, 4'hE);
      chk(false_carrier == 1'b0, "R10 fc single", false_carrier, 0);
      cyc(1'b0, 1'b0, 4'h0);
      cyc(1'b0, 1'b1, 4'hE);
      chk(false_carrier == 1'b1, "R10 fc second occurrence", false_carrier, 1);
      cyc(1'b0, 1'b0, 4'h0);

      // directed: error line high with data 0x1 inside a frame (R11)
      cyc(1'b1, 1'b1, 4'h1);
      chk(!lpi_seen && !false_carrier, "R11 in-frame code", lpi_seen, 0);
      cyc(1'b0, 1'b0, 4'h0);

      // random sideband with other codes (R11)
      for (int i = 0; i < 40; i++) begin
         logic [3:0] v;
         v = 4'($urandom);
         if (v == 4'h1 || v == 4'hE) v = 4'h7;
         cyc(1'b0, 1'b1, v);
         chk(!lpi_seen && !false_carrier, "R11 other code", {lpi_seen, false_carrier}, 0);
      end
      cyc(1'b0, 1'b0, 4'h0);

      // random frames
      for (int f = 0; f < 80; f++) begin
         int p, n, ep;
         bit odd;
         p   = 1 + int'($urandom % 7);
         n   = int'($urandom % 21);
         odd = ($urandom % 4) == 0;
         ep  = (($urandom % 3) == 0) ? int'($urandom % (p + 1 + 2*n + 1)) : -1;
         if (ep > p + 2*n + (odd ? 1 : 0)) ep = -1;
         run_frame(p, n, odd, ep);
      end

      if (!done) begin
         done = 1;
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end
endmodule